// File: doc/BRIEF.md
# Lattice Ciphertext Bit Decoder

This block turns one learning-with-errors ciphertext into the plaintext bit it carries. A private key, a vector of N residues modulo Q, is written beforehand through a small indexed write port and held in registers. A ciphertext then streams in over a valid/ready channel: N vector elements in index order, followed by one final element holding the ciphertext sum. Each vector element is multiplied by the key element of the same index and accumulated at full width.

When the sum element arrives, the block forms sum minus the dot product, plus a multiple of Q large enough that the result can never go negative. It hands that value to a modulo reducer. By default the reducer is a shift-and-subtract state machine; a parameter swaps in a single-cycle variant instead. The reduced distance d decides the bit. A value of d near Q/2 means 1, and a value near zero, on either side, means 0. The bit leaves with a one-cycle valid strobe, and the input channel stays closed from the sum beat until that strobe.

Top module: `lwe_decrypt_bit`

## Requirements
- R1: During and straight after reset, `ct_ready` is 1 and `bit_valid` is 0.
- R2: A cycle with `key_we` high stores `key_val` as key element `key_idx`. Vector element j of a ciphertext is always paired with key element j, and a key rewritten between ciphertexts takes effect for the next one.
- R3: A beat is taken only on a rising edge where `ct_valid` and `ct_ready` are both 1. The first N beats of a ciphertext are the vector elements 0..N-1, and beat N+1 is the sum.
- R4: `ct_data` has no effect while `ct_valid` is 0. Idle cycles between beats leave the result unchanged.
- R5: With all inputs in [0, Q), the decoded distance is d = (sum - Σ c_j·s_j) mod Q, exact for every input value including the largest possible dot product.
- R6: `bit_out` is 1 when 4·d ≥ Q and 4·d < 3·Q, and 0 otherwise. A ciphertext built as dot + m·⌊Q/2⌋ + e with |e| < Q/4 − 1 therefore decodes to m.
- R7: From the cycle after the sum beat is taken until `bit_valid` rises, `ct_ready` is 0. `bit_valid` stays high for exactly one cycle.
- R8: `ct_ready` is 1 in the cycle where `bit_valid` is 1, so the next ciphertext may start at once.
- R9: The number of cycles from taking the sum beat to `bit_valid` is the same for every ciphertext, whatever its values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_we | input | 1 | Key element write strobe |
| key_idx | input | max(1, clog2(N)) | Index of the key element to write |
| key_val | input | clog2(Q+1) | Key element value, in [0, Q) |
| ct_valid | input | 1 | Ciphertext beat present |
| ct_ready | output | 1 | Block accepts a ciphertext beat |
| ct_data | input | clog2(Q+1) | Ciphertext element or sum, in [0, Q) |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| bit_out | output | 1 | Decoded plaintext bit |

## Verification
The bench builds the block with N = 4 and Q = 97, using the iterative reducer. A modulus this small lets it drive every one of the 97 possible distances d through a full ciphertext, with random vectors and random keys. That covers both sides of each decision threshold exhaustively, as well as the zero and all-maximum dot products. Beyond that sweep, it encrypts a few hundred random bits with noise inside the safe band and inserts idle cycles carrying junk data. It also rewrites the key partway through the run, and it compares the latency of every ciphertext against the first one.

// File: rtl/lwe_dec_pkg.sv
package lwe_dec_pkg;

   typedef enum logic {
      ST_COLLECT = 1'b0,
      ST_REDUCE  = 1'b1
   } dec_state_e;

endpackage

// File: rtl/lwe_key_store.sv
module lwe_key_store #(
   parameter int N   = 16,
   parameter int EW  = 12,
   parameter int KIW = 4,
   parameter int IW  = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [KIW-1:0] wr_idx,
   input  logic [EW-1:0]  wr_val,
   input  logic [IW-1:0]  rd_idx,
   output logic [EW-1:0]  rd_val
);

   logic [EW-1:0] elem [N];

   for (genvar g = 0; g < N; g++) begin : g_elem
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            elem[g] <= '0;
         else if (we && (wr_idx == KIW'(g)))
            elem[g] <= wr_val;
      end
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < N; i++)
         if (rd_idx == IW'(i)) rd_val = elem[i];
   end

endmodule

// File: rtl/lwe_mac.sv
module lwe_mac #(
   parameter int EW = 12,
   parameter int AW = 29
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [EW-1:0] a,
   input  logic [EW-1:0] b,
   output logic [AW-1:0] acc
);

   logic [AW-1:0] prod;

   assign prod = AW'(a) * AW'(b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (clr)
         acc <= '0;
      else if (en)
         acc <= acc + prod;
   end

endmodule

// File: rtl/lwe_mod_reduce.sv
module lwe_mod_reduce #(
   parameter int Q         = 3329,
   parameter int XW        = 30,
   parameter int QB        = 12,
   parameter bit ITERATIVE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [XW-1:0] x_in,
   output logic          done,
   output logic [QB-1:0] r_out
);

   localparam int SH = XW - QB;
   localparam int SW = (SH > 0) ? $clog2(SH + 1) : 1;

   logic [XW-1:0] rem;

   if (SH < 1) begin : g_bad_width
      $error("lwe_mod_reduce: XW must exceed QB");
   end

   if (ITERATIVE) begin : g_iter
      logic [SW-1:0] cnt;
      logic          busy;
      logic [XW-1:0] dvs;

      assign dvs = XW'(Q) << cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rem  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
         end else begin
            done <= 1'b0;
            if (start) begin
               rem  <= x_in;
               cnt  <= SW'(SH);
               busy <= 1'b1;
            end else if (busy) begin
               if (rem >= dvs) rem <= rem - dvs;
               if (cnt == '0) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         end
      end
   end else begin : g_flat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rem  <= '0;
            done <= 1'b0;
         end else begin
            done <= start;
            if (start) rem <= x_in % XW'(Q);
         end
      end
   end

   assign r_out = rem[QB-1:0];

endmodule

// File: rtl/lwe_decrypt_bit.sv
module lwe_decrypt_bit #(
   parameter int N         = 16,
   parameter int Q         = 3329,
   parameter bit ITERATIVE = 1'b1,
   localparam int QB       = $clog2(Q + 1),
   localparam int KIW      = (N > 1) ? $clog2(N) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           key_we,
   input  logic [KIW-1:0] key_idx,
   input  logic [QB-1:0]  key_val,
   input  logic           ct_valid,
   output logic           ct_ready,
   input  logic [QB-1:0]  ct_data,
   output logic           bit_valid,
   output logic           bit_out
);

   import lwe_dec_pkg::*;

   localparam int    IW     = $clog2(N + 1);
   localparam int    AW     = 2 * QB + $clog2(N + 1);
   localparam int    XW     = AW + 1;
   localparam longint KMUL  = ((longint'(1) << AW) + longint'(Q) - 1) / longint'(Q);
   localparam logic [XW-1:0] OFFS = XW'(KMUL * longint'(Q));

   if (Q < 4) begin : g_bad_q
      $error("lwe_decrypt_bit: Q must be at least 4");
   end
   if (N < 2) begin : g_bad_n
      $error("lwe_decrypt_bit: N must be at least 2");
   end

   dec_state_e      st;
   logic [IW-1:0]   idx;
   logic            fire;
   logic            last_beat;
   logic [QB-1:0]   key_rd;
   logic [AW-1:0]   acc;
   logic [XW-1:0]   red_x;
   logic            red_start;
   logic            red_done;
   logic [QB-1:0]   red_r;
   logic [QB+1:0]   d4;
   logic            near_half;

   assign ct_ready  = (st == ST_COLLECT);
   assign fire      = ct_valid && ct_ready;
   assign last_beat = (idx == IW'(N));
   assign red_start = fire && last_beat;
   assign red_x     = OFFS + XW'(ct_data) - XW'(acc);

   assign d4        = {red_r, 2'b00};
   assign near_half = (d4 >= (QB+2)'(Q)) && (d4 < (QB+2)'(3 * Q));

   lwe_key_store #(.N(N), .EW(QB), .KIW(KIW), .IW(IW)) u_keys (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (key_we),
      .wr_idx (key_idx),
      .wr_val (key_val),
      .rd_idx (idx),
      .rd_val (key_rd)
   );

   lwe_mac #(.EW(QB), .AW(AW)) u_mac (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (red_start),
      .en    (fire && !last_beat),
      .a     (ct_data),
      .b     (key_rd),
      .acc   (acc)
   );

   lwe_mod_reduce #(.Q(Q), .XW(XW), .QB(QB), .ITERATIVE(ITERATIVE)) u_red (
      .clk   (clk),
      .rst_n (rst_n),
      .start (red_start),
      .x_in  (red_x),
      .done  (red_done),
      .r_out (red_r)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_COLLECT;
         idx       <= '0;
         bit_valid <= 1'b0;
         bit_out   <= 1'b0;
      end else begin
         bit_valid <= 1'b0;
         unique case (st)
            ST_COLLECT: begin
               if (fire) begin
                  if (last_beat) begin
                     idx <= '0;
                     st  <= ST_REDUCE;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_REDUCE: begin
               if (red_done) begin
                  bit_valid <= 1'b1;
                  bit_out   <= near_half;
                  st        <= ST_COLLECT;
               end
            end
            default: st <= ST_COLLECT;
         endcase
      end
   end

endmodule

// File: rtl/lwe_decrypt_bit_chk.sv
module lwe_decrypt_bit_chk #(
   parameter int N  = 16,
   parameter int Q  = 3329,
   parameter int IW = 5,
   parameter int QB = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ct_valid,
   input logic          ct_ready,
   input logic          bit_valid,
   input logic          bit_out,
   input logic [IW-1:0] beat_idx,
   input logic          red_done,
   input logic [QB-1:0] red_r
);

   AST_BEAT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      beat_idx <= IW'(N)); // R3

   AST_CLOSED_AFTER_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (ct_valid && ct_ready && beat_idx == IW'(N)) |=> !ct_ready); // R7

   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |=> !bit_valid); // R7

   AST_STROBE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bit_valid) |-> $past(!ct_ready)); // R7

   AST_OPEN_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> ct_ready); // R8

   AST_REDUCED_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      red_done |-> (red_r < QB'(Q))); // R5

   AST_BIT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> !$isunknown(bit_out)); // R6

endmodule

bind lwe_decrypt_bit lwe_decrypt_bit_chk #(.N(N), .Q(Q), .IW(IW), .QB(QB)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ct_valid  (ct_valid),
   .ct_ready  (ct_ready),
   .bit_valid (bit_valid),
   .bit_out   (bit_out),
   .beat_idx  (idx),
   .red_done  (red_done),
   .red_r     (red_r)
);

// File: tb/lwe_decrypt_bit_tb.sv
module lwe_decrypt_bit_tb;

   localparam int N   = 4;
   localparam int Q   = 97;
   localparam int QB  = $clog2(Q + 1);
   localparam int KIW = $clog2(N);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           key_we = 1'b0;
   logic [KIW-1:0] key_idx = '0;
   logic [QB-1:0]  key_val = '0;
   logic           ct_valid = 1'b0;
   logic           ct_ready;
   logic [QB-1:0]  ct_data = '0;
   logic           bit_valid;
   logic           bit_out;

   int checks = 0;
   int fails  = 0;
   int ref_lat = -1;
   bit finished = 1'b0;
   int skey [N];
   int cvec [N];

   always #2 clk = ~clk;

   lwe_decrypt_bit #(.N(N), .Q(Q), .ITERATIVE(1'b1)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_we    (key_we),
      .key_idx   (key_idx),
      .key_val   (key_val),
      .ct_valid  (ct_valid),
      .ct_ready  (ct_ready),
      .ct_data   (ct_data),
      .bit_valid (bit_valid),
      .bit_out   (bit_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic int expect_bit(input int d);
      return ((4 * d >= Q) && (4 * d < 3 * Q)) ? 1 : 0;
   endfunction

   function automatic int dot_mod();
      longint s = 0;
      for (int j = 0; j < N; j++) s += longint'(cvec[j]) * longint'(skey[j]);
      return int'(s % Q);
   endfunction

   task automatic write_key();
      for (int j = 0; j < N; j++) begin
         @(negedge clk);
         key_we  = 1'b1;
         key_idx = KIW'(j);
         key_val = QB'(skey[j]);
      end
      @(negedge clk);
      key_we = 1'b0;
   endtask

   task automatic send_beat(input int v, input bit bubble);
      if (bubble) begin
         @(negedge clk);
         ct_valid = 1'b0;
         ct_data  = QB'($urandom_range(0, (1 << QB) - 1));
      end
      @(negedge clk);
      ct_valid = 1'b1;
      ct_data  = QB'(v);
      while (!ct_ready) @(negedge clk);
      @(posedge clk);
   endtask

   // Sends cvec then sum; returns the decoded bit (R3, R7, R8, R9 checked here)
   task automatic decrypt(input int sum, input bit bubbles, output int got);
      int lat;
      bit closed;
      for (int j = 0; j < N; j++) send_beat(cvec[j], bubbles && (j % 2 == 0));
      send_beat(sum, bubbles);
      lat = 0;
      closed = 1'b1;
      got = -1;
      while (lat < 200) begin
         @(negedge clk);
         ct_valid = 1'b0;
         ct_data  = QB'($urandom_range(0, (1 << QB) - 1));
         lat++;
         if (bit_valid) begin
            got = int'(bit_out);
            break;
         end
         if (ct_ready) closed = 1'b0;
      end
      check(got >= 0, "R3 strobe after N+1 beats", got, 0);
      check(closed, "R7 ready low while busy", int'(closed), 1);
      check(ct_ready == 1'b1, "R8 ready at strobe", int'(ct_ready), 1);
      if (ref_lat < 0) ref_lat = lat;
      check(lat == ref_lat, "R9 constant latency", lat, ref_lat);
      @(negedge clk);
      check(bit_valid == 1'b0, "R7 single-cycle strobe", int'(bit_valid), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int got;
      int d;
      int m;
      int e;
      int sum;

      repeat (3) @(negedge clk);
      check(ct_ready == 1'b1, "R1 ready in reset", int'(ct_ready), 1);
      check(bit_valid == 1'b0, "R1 no strobe in reset", int'(bit_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(ct_ready == 1'b1, "R1 ready after reset", int'(ct_ready), 1);
      check(bit_valid == 1'b0, "R1 no strobe after reset", int'(bit_valid), 0);

      for (int j = 0; j < N; j++) skey[j] = $urandom_range(0, Q - 1);
      write_key();

      // R5 R6: every distance d, both sides of both thresholds; R4 with bubbles
      for (int dd = 0; dd < Q; dd++) begin
         for (int j = 0; j < N; j++) cvec[j] = $urandom_range(0, Q - 1);
         sum = (dot_mod() + dd) % Q;
         decrypt(sum, (dd % 3) == 0, got);
         check(got == expect_bit(dd), "R6 threshold sweep", got, expect_bit(dd));
      end

      // R5: zero vector and the largest dot product
      for (int j = 0; j < N; j++) cvec[j] = 0;
      decrypt(Q / 2, 1'b0, got);
      check(got == 1, "R5 zero vector", got, 1);
      for (int j = 0; j < N; j++) begin
         skey[j] = Q - 1;
         cvec[j] = Q - 1;
      end
      write_key();
      for (int k = 0; k < 4; k++) begin
         d   = (k == 0) ? 0 : (k == 1) ? (Q + 3) / 4 : (k == 2) ? Q / 2 : Q - 1;
         sum = (dot_mod() + d) % Q;
         decrypt(sum, 1'b0, got);
         check(got == expect_bit(d), "R5 maximum dot product", got, expect_bit(d));
      end

      // R2: one-hot key pins element order; key rewrite takes effect
      for (int p = 0; p < N; p++) begin
         for (int j = 0; j < N; j++) begin
            skey[j] = (j == p) ? 1 : 0;
            cvec[j] = 10 + 20 * j;
         end
         write_key();
         sum = (cvec[p] + Q / 2) % Q;
         decrypt(sum, 1'b0, got);
         check(got == 1, "R2 key element pairing", got, 1);
      end

      // R6: encrypt random bits with small noise
      for (int j = 0; j < N; j++) skey[j] = $urandom_range(0, Q - 1);
      write_key();
      for (int t = 0; t < 300; t++) begin
         m = $urandom_range(0, 1);
         e = $urandom_range(0, 40) - 20;
         for (int j = 0; j < N; j++) cvec[j] = $urandom_range(0, Q - 1);
         sum = ((dot_mod() + m * (Q / 2) + e) % Q + Q) % Q;
         decrypt(sum, (t % 5) == 0, got);
         check(got == m, "R6 noisy round trip", got, m);
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule